// File: doc/BRIEF.md
# Shared RAM Window Arbiter with Mailbox Flag

This block lets two agents share one on-board RAM. The local processor sees the RAM at a fixed range of its own address space. An external bus master sees the same RAM through a window, and a set of static configuration pins picks the window's size and its base address. The arbiter serves one access at a time. When both sides ask in the same cycle the local side wins, but the arbiter never cuts off an external access that it has already granted.

An external write to offset zero of the window raises a flag interrupt towards the local processor. The bus master uses it as a doorbell. The local processor drops the flag by reading that same location, local address 8000h.

Each side talks to the block through a request/acknowledge pair. A requester raises its valid signal together with address, direction and write data, and holds them until it sees ready high. Ready is high for exactly one cycle. Read data is valid in that cycle. The requester may drop valid, or change the request, at the clock edge that ends that cycle. There is no other back-pressure. A request that is never decoded as a hit never receives ready, and the requester may withdraw it at any time. The RAM is modelled as a synchronous array of 2^STORE_AW bytes. Offsets fold onto that depth, so a full 16 KB build sets STORE_AW to 14.

Top module: `dpram_window_arb`

## Requirements
- R1: A local request is served only when loc_addr[15:14] = 2'b10, which is the range 8000h–BFFFh. The RAM offset is loc_addr[13:0]. A local request outside that range never receives loc_ready.
- R2: cfg_size selects the window size: 2'b00 is 4 KB, 2'b01 is 8 KB and 2'b10 is 16 KB. Code 2'b11 disables all external access, so ext_ready never rises.
- R3: cfg_base gives external address bits 15:12 of the window base. A base that is not aligned to the selected size disables all external access. An 8 KB window needs cfg_base[0] = 0. A 16 KB window needs cfg_base[1:0] = 2'b00.
- R4: An external request whose address falls outside the configured window never receives ext_ready and has no effect on the RAM or on the flag.
- R5: When cfg_wide = 1, external address bits 19:16 must equal cfg_seg for a hit. When cfg_wide = 0, those bits are ignored.
- R6: When local and external requests are pending in an idle cycle, the local one is granted first. An external access that has already been granted always completes, and a local request that arrives during it is served afterwards.
- R7: An access granted from idle gives ready on the following cycle, and read data is valid in that same cycle. The arbiter returns to idle for one cycle before it makes the next grant.
- R8: An external write that hits window offset 0 sets flag_irq. The flag is high in the same cycle as that write's ext_ready.
- R9: A local read of 8000h clears flag_irq, and the flag is low in the cycle of that read's loc_ready. Local writes and local reads of other addresses leave the flag unchanged.
- R10: An external hit at window offset k accesses the same byte as a local access to 8000h + k.
- R11: During and straight after reset, flag_irq, loc_ready and ext_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Window size code |
| cfg_base | input | 4 | Window base, external address bits 15:12 |
| cfg_wide | input | 1 | 1 = 20-bit external addressing |
| cfg_seg | input | EXT_AW-16 | Segment select for 20-bit addressing |
| loc_valid | input | 1 | Local request |
| loc_addr | input | 16 | Local address |
| loc_we | input | 1 | Local write when 1 |
| loc_wdata | input | DATA_W | Local write data |
| loc_ready | output | 1 | Local access complete |
| loc_rdata | output | DATA_W | Local read data, valid with loc_ready |
| ext_valid | input | 1 | External request |
| ext_addr | input | EXT_AW | External address |
| ext_we | input | 1 | External write when 1 |
| ext_wdata | input | DATA_W | External write data |
| ext_ready | output | 1 | External access complete |
| ext_rdata | output | DATA_W | External read data, valid with ext_ready |
| flag_irq | output | 1 | Mailbox flag interrupt to the local processor |

## Verification
A request presented to an idle arbiter gets ready at the first falling edge after its grant edge, so ready is due one cycle after the request is driven. The flag changes in that same cycle. A request that loses arbitration, or that arrives while the other side's access is running, gets ready three cycles after it was driven. A local request that arrives in the ready cycle of an external access gets ready two cycles after it was driven. The bench drives every request on a falling edge and counts falling edges until ready. It compares that count, the read data and the flag against these fixed latencies. A request that should miss is watched for four cycles and must never get ready.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  localparam int WIN_OFF_W = 14;
  localparam int LOC_AW    = 16;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_LDONE = 2'd1,
    ARB_EDONE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dpw_window_dec.sv
module dpw_window_dec #(
  parameter int EXT_AW = 20,
  localparam int SEG_W = EXT_AW - 16,
  localparam int OFF_W = dpw_pkg::WIN_OFF_W
) (
  input  logic [1:0]        cfg_size,
  input  logic [3:0]        cfg_base,
  input  logic              cfg_wide,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [EXT_AW-1:0] ext_addr,
  output logic              win_hit,
  output logic [OFF_W-1:0]  win_off
);
  logic [3:0] hi_mask;
  logic       size_ok, align_ok, seg_ok, base_ok;

  always_comb begin
    case (cfg_size)
      2'b00:   hi_mask = 4'b1111;
      2'b01:   hi_mask = 4'b1110;
      2'b10:   hi_mask = 4'b1100;
      default: hi_mask = 4'b0000;
    endcase
    size_ok  = (cfg_size != 2'b11);
    align_ok = ((cfg_base & ~hi_mask) == 4'b0000);
    seg_ok   = !cfg_wide || (ext_addr[EXT_AW-1:16] == cfg_seg);
    base_ok  = (((ext_addr[15:12] ^ cfg_base) & hi_mask) == 4'b0000);
    win_hit  = size_ok && align_ok && seg_ok && base_ok;
    win_off  = {ext_addr[13:12] & ~hi_mask[1:0], ext_addr[11:0]};
  end
endmodule

// File: rtl/dpw_arbiter.sv
module dpw_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req,
  input  logic ext_req,
  output logic gnt_loc,
  output logic gnt_ext,
  output logic loc_done,
  output logic ext_done
);
  import dpw_pkg::*;
  arb_state_e state_q, state_d;

  always_comb begin
    gnt_loc = (state_q == ARB_IDLE) && loc_req;
    gnt_ext = (state_q == ARB_IDLE) && ext_req && !loc_req;
    state_d = ARB_IDLE;
    if (gnt_loc)      state_d = ARB_LDONE;
    else if (gnt_ext) state_d = ARB_EDONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign loc_done = (state_q == ARB_LDONE);
  assign ext_done = (state_q == ARB_EDONE);
endmodule

// File: rtl/dpw_ram.sv
module dpw_ram #(
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 11,
  parameter int ADDR_W   = 14,
  localparam int DEPTH   = 2 ** STORE_AW
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  int unsigned idx;

  assign idx = int'(addr) % DEPTH;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/dpw_mailbox.sv
module dpw_mailbox (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dpram_window_arb.sv
module dpram_window_arb #(
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 11,
  parameter int EXT_AW   = 20,
  localparam int SEG_W   = EXT_AW - 16,
  localparam int OFF_W   = dpw_pkg::WIN_OFF_W,
  localparam int LOC_AW  = dpw_pkg::LOC_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic [3:0]        cfg_base,
  input  logic              cfg_wide,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic              loc_valid,
  input  logic [LOC_AW-1:0] loc_addr,
  input  logic              loc_we,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic              loc_ready,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              ext_valid,
  input  logic [EXT_AW-1:0] ext_addr,
  input  logic              ext_we,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic              ext_ready,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              flag_irq
);
  logic              win_hit, loc_hit, ext_hit;
  logic [OFF_W-1:0]  win_off, loc_off, sel_off;
  logic              gnt_loc, gnt_ext;
  logic              ram_en, ram_we;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic              mb_set, mb_clr;

  dpw_window_dec #(.EXT_AW(EXT_AW)) u_dec (
    .cfg_size(cfg_size), .cfg_base(cfg_base), .cfg_wide(cfg_wide),
    .cfg_seg(cfg_seg), .ext_addr(ext_addr),
    .win_hit(win_hit), .win_off(win_off)
  );

  assign loc_hit = loc_valid && (loc_addr[15:14] == 2'b10);
  assign loc_off = loc_addr[OFF_W-1:0];
  assign ext_hit = ext_valid && win_hit;

  dpw_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .loc_req(loc_hit), .ext_req(ext_hit),
    .gnt_loc(gnt_loc), .gnt_ext(gnt_ext),
    .loc_done(loc_ready), .ext_done(ext_ready)
  );

  always_comb begin
    ram_en    = gnt_loc || gnt_ext;
    ram_we    = gnt_loc ? loc_we    : (gnt_ext && ext_we);
    sel_off   = gnt_loc ? loc_off   : win_off;
    ram_wdata = gnt_loc ? loc_wdata : ext_wdata;
  end

  dpw_ram #(.DATA_W(DATA_W), .STORE_AW(STORE_AW), .ADDR_W(OFF_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(sel_off),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  assign loc_rdata = ram_q;
  assign ext_rdata = ram_q;

  assign mb_set = gnt_ext && ext_we && (win_off == '0);
  assign mb_clr = gnt_loc && !loc_we && (loc_off == '0);

  dpw_mailbox u_mb (
    .clk(clk), .rst_n(rst_n), .set_i(mb_set), .clr_i(mb_clr), .flag_o(flag_irq)
  );
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_size,
  input logic        loc_ready,
  input logic        loc_we,
  input logic [15:0] loc_addr,
  input logic        ext_ready,
  input logic        ext_we,
  input logic        ext_hit,
  input logic        gnt_loc,
  input logic        gnt_ext,
  input logic        flag_irq
);
  // R7: a local grant completes on the next cycle
  a_r7_loc_ready_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_loc |=> loc_ready && !ext_ready);

  // R6: a granted external access is never cut off by a local request
  a_r6_ext_never_aborted: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_ext |=> ext_ready && !loc_ready);

  // R4: only a decoded hit ever completes on the external side
  a_r4_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> $past(ext_hit));

  // R2: the invalid size code locks out external access
  a_r2_invalid_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> ($past(cfg_size) != 2'b11));

  // R8: the flag only rises with an external write completing
  a_r8_flag_rise_on_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_irq) |-> ext_ready && ext_we);

  // R9: the flag only falls with a local read of the base
  a_r9_flag_fall_on_base_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_irq) |-> loc_ready && !loc_we && (loc_addr == 16'h8000));

  // R6: at most one side completes per cycle
  a_r6_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_ready, ext_ready}));
endmodule

bind dpram_window_arb dpw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size),
  .loc_ready(loc_ready), .loc_we(loc_we), .loc_addr(loc_addr),
  .ext_ready(ext_ready), .ext_we(ext_we), .ext_hit(ext_hit),
  .gnt_loc(gnt_loc), .gnt_ext(gnt_ext), .flag_irq(flag_irq)
);

// File: tb/dpram_window_arb_tb_top.sv
`timescale 1ns/100ps
module dpram_window_arb_tb_top;
  localparam int MAXW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size = 2'b00;
  logic [3:0]  cfg_base = 4'h0;
  logic        cfg_wide = 1'b0;
  logic [3:0]  cfg_seg = 4'h0;
  logic        loc_valid = 1'b0, loc_we = 1'b0;
  logic [15:0] loc_addr = '0;
  logic [7:0]  loc_wdata = '0;
  logic        loc_ready;
  logic [7:0]  loc_rdata;
  logic        ext_valid = 1'b0, ext_we = 1'b0;
  logic [19:0] ext_addr = '0;
  logic [7:0]  ext_wdata = '0;
  logic        ext_ready;
  logic [7:0]  ext_rdata;
  logic        flag_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dpram_window_arb dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .cfg_wide(cfg_wide), .cfg_seg(cfg_seg),
    .loc_valid(loc_valid), .loc_addr(loc_addr), .loc_we(loc_we),
    .loc_wdata(loc_wdata), .loc_ready(loc_ready), .loc_rdata(loc_rdata),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_we(ext_we),
    .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
    .flag_irq(flag_irq)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic [3:0]  base;
    logic        wide;
    logic [3:0]  seg;
    logic [19:0] addr;
    logic        hit;
    logic [15:0] laddr;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{2'd0, 4'h3, 1'b0, 4'h0, 20'h03010, 1'b1, 16'h8010},
    '{2'd0, 4'h3, 1'b0, 4'h0, 20'h04010, 1'b0, 16'h0000},
    '{2'd1, 4'h2, 1'b0, 4'h0, 20'h03FFE, 1'b1, 16'h9FFE},
    '{2'd1, 4'h2, 1'b0, 4'h0, 20'h01000, 1'b0, 16'h0000},
    '{2'd1, 4'h3, 1'b0, 4'h0, 20'h03004, 1'b0, 16'h0000},
    '{2'd2, 4'h4, 1'b0, 4'h0, 20'h07ABC, 1'b1, 16'hBABC},
    '{2'd2, 4'h4, 1'b0, 4'h0, 20'h08000, 1'b0, 16'h0000},
    '{2'd2, 4'h6, 1'b0, 4'h0, 20'h06004, 1'b0, 16'h0000},
    '{2'd3, 4'h0, 1'b0, 4'h0, 20'h00004, 1'b0, 16'h0000},
    '{2'd0, 4'h0, 1'b0, 4'h0, 20'hF0123, 1'b1, 16'h8123},
    '{2'd0, 4'h0, 1'b1, 4'h5, 20'h50123, 1'b1, 16'h8123},
    '{2'd0, 4'h0, 1'b1, 4'h5, 20'h40123, 1'b0, 16'h0000},
    '{2'd2, 4'h0, 1'b1, 4'hA, 20'hA3FFF, 1'b1, 16'hBFFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loc_xfer(input logic [15:0] a, input bit we, input logic [7:0] d,
                          output int waits, output logic [7:0] q);
    loc_addr = a; loc_we = we; loc_wdata = d; loc_valid = 1'b1;
    waits = 0; q = '0;
    for (int k = 1; k <= MAXW; k++) begin
      @(negedge clk);
      if (loc_ready) begin waits = k; q = loc_rdata; break; end
    end
    if (waits != 0) begin
      @(posedge clk); #1 loc_valid = 1'b0;
      @(negedge clk);
    end else loc_valid = 1'b0;
  endtask

  task automatic ext_xfer(input logic [19:0] a, input bit we, input logic [7:0] d,
                          output int waits, output logic [7:0] q);
    ext_addr = a; ext_we = we; ext_wdata = d; ext_valid = 1'b1;
    waits = 0; q = '0;
    for (int k = 1; k <= MAXW; k++) begin
      @(negedge clk);
      if (ext_ready) begin waits = k; q = ext_rdata; break; end
    end
    if (waits != 0) begin
      @(posedge clk); #1 ext_valid = 1'b0;
      @(negedge clk);
    end else ext_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w, w2;
    logic [7:0] q, q2;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(!flag_irq && !loc_ready && !ext_ready, "R11", "outputs in reset",
        {flag_irq, loc_ready, ext_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!flag_irq && !loc_ready && !ext_ready, "R11", "outputs after reset",
        {flag_irq, loc_ready, ext_ready}, 0);

    // table walk: R2 R3 R4 R5 R10
    foreach (VEC[i]) begin
      cfg_size = VEC[i].size; cfg_base = VEC[i].base;
      cfg_wide = VEC[i].wide; cfg_seg = VEC[i].seg;
      @(negedge clk);
      ext_xfer(VEC[i].addr, 1'b1, 8'h40 + 8'(i), w, q);
      if (VEC[i].hit) begin
        chk(w == 1, "R2/R3/R5", $sformatf("vec %0d write latency", i), w, 1);
        loc_xfer(VEC[i].laddr, 1'b0, 8'h00, w, q);
        chk(w == 1 && q == 8'h40 + 8'(i), "R10", $sformatf("vec %0d local view", i),
            q, 8'h40 + 8'(i));
        ext_xfer(VEC[i].addr, 1'b0, 8'h00, w, q);
        chk(w == 1 && q == 8'h40 + 8'(i), "R7", $sformatf("vec %0d ext read", i),
            q, 8'h40 + 8'(i));
      end else begin
        chk(w == 0, "R4", $sformatf("vec %0d miss gets no ready", i), w, 0);
      end
      chk(!flag_irq, "R8", $sformatf("vec %0d flag stays low", i), flag_irq, 0);
    end

    // R1: local range limits
    loc_xfer(16'h7F00, 1'b1, 8'h11, w, q);
    chk(w == 0, "R1", "below range no ready", w, 0);
    loc_xfer(16'hC000, 1'b1, 8'h12, w, q);
    chk(w == 0, "R1", "above range no ready", w, 0);
    loc_xfer(16'hBFFE, 1'b1, 8'h13, w, q);
    chk(w == 1, "R1", "top of range served", w, 1);

    // R4: missed write leaves RAM intact
    cfg_size = 2'b00; cfg_base = 4'h1; cfg_wide = 1'b0;
    loc_xfer(16'h8020, 1'b1, 8'h5A, w, q);
    ext_xfer(20'h02020, 1'b1, 8'hA5, w, q);
    chk(w == 0, "R4", "miss write no ready", w, 0);
    loc_xfer(16'h8020, 1'b0, 8'h00, w, q);
    chk(q == 8'h5A, "R4", "miss write no effect", q, 8'h5A);

    // R8 R9: mailbox flag
    cfg_size = 2'b01; cfg_base = 4'h2;
    @(negedge clk);
    ext_xfer(20'h02000, 1'b1, 8'hC3, w, q);
    chk(w == 1 && flag_irq, "R8", "base write sets flag", flag_irq, 1);
    loc_xfer(16'h8000, 1'b1, 8'h3C, w, q);
    chk(flag_irq, "R9", "local write keeps flag", flag_irq, 1);
    loc_xfer(16'h8001, 1'b0, 8'h00, w, q);
    chk(flag_irq, "R9", "other read keeps flag", flag_irq, 1);
    ext_addr = 20'h02000; ext_we = 1'b0; ext_valid = 1'b1;
    @(negedge clk);
    chk(ext_ready && flag_irq, "R8", "base read keeps flag", flag_irq, 1);
    @(posedge clk); #1 ext_valid = 1'b0;
    @(negedge clk);
    loc_addr = 16'h8000; loc_we = 1'b0; loc_valid = 1'b1;
    @(negedge clk);
    chk(loc_ready && !flag_irq, "R9", "base read clears flag", flag_irq, 0);
    chk(loc_rdata == 8'h3C, "R10", "base byte value", loc_rdata, 8'h3C);
    @(posedge clk); #1 loc_valid = 1'b0;
    @(negedge clk);

    // R6: simultaneous requests, local first
    fork
      loc_xfer(16'h8040, 1'b1, 8'h77, w, q);
      ext_xfer(20'h02040, 1'b0, 8'h00, w2, q2);
    join
    chk(w == 1, "R6", "local wins tie latency", w, 1);
    chk(w2 == 3, "R6", "external waits latency", w2, 3);
    chk(q2 == 8'h77, "R6", "external sees local write", q2, 8'h77);

    // R6: local arriving during an external access waits
    loc_xfer(16'h8050, 1'b1, 8'h21, w, q);
    fork
      ext_xfer(20'h02050, 1'b1, 8'h99, w2, q2);
      begin @(negedge clk); loc_xfer(16'h8050, 1'b0, 8'h00, w, q); end
    join
    chk(w2 == 1, "R6", "external not aborted", w2, 1);
    chk(w == 2, "R6", "late local latency", w, 2);
    chk(q == 8'h99, "R6", "local reads completed ext write", q, 8'h99);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule